// File: doc/BRIEF.md
# ADC Channel Select and Conversion Sequencer

This block sits between a processor bus and a multiplexed 12-bit analog-to-digital converter. The converter is fed from 64 per-channel track-and-hold circuits. Software reaches two 16-bit words, selected by one address bit. The control word picks the channel, starts conversions, holds the interrupt enable, shows completion and two alarm flags, and carries a write-only strobe that resets the arm safety logic. The read-only sample word returns the last result, sign-extended.

Software starts a conversion by writing the channel byte. Re-sampling the inputs is a separate step: writing one to the hold bit freezes every track-and-hold at the same instant and then converts the selected channel. Software can then step through further channels by writing the channel byte, and every one of them comes from the same frozen instant. Clearing the hold bit lets the inputs track again. The multiplexer and the converter are modelled as a start pulse with a channel number, followed some cycles later by a done pulse with data.

Top module: `adc_seq`

## Requirements
- R1: After synchronous reset, both readable words are zero apart from the live alarm bits, and irq_o, hold_o, conv_start_o and arm_reset_o are all low.
- R2: The control word (address bit 0) has this layout: channel in bits 13..8, DONE in bit 7, interrupt enable in bit 6, arm-reset strobe in bit 3 (always reads 0), power-glitch alarm in bit 2, panic alarm in bit 1, hold in bit 0. All other bits read 0. A read returns its value on bus_rdata_o in the cycle after the read request.
- R3: A write with byte enable 1 (bits 15..8) latches the channel. conv_start_o then pulses once, two cycles after the write edge, with conv_chan_o equal to that channel. hold_o does not change.
- R4: A byte-0 write with bit 0 set drives hold_o high in the cycle after the write edge and pulses conv_start_o one cycle later. A write of both bytes with bit 0 set issues exactly one conversion, on the newly written channel.
- R5: A byte-0 write with bit 0 clear drives hold_o low, issues no conversion and leaves DONE unchanged.
- R6: DONE goes to 1 on the edge that samples an accepted conv_done_i. Any write that starts a conversion clears it on its own edge.
- R7: irq_o equals DONE AND interrupt-enable, changes on the same edge as either of them, and irq_vec_o is the constant 8'h5C.
- R8: The sample word (address bit 1) returns the 12-bit two's-complement result sign-extended to 16 bits: 12'h7FF reads 16'h07FF and 12'h800 reads 16'hF800.
- R9: The sample word keeps its last result while a new conversion is in flight, and it changes on the same edge on which DONE rises.
- R10: A byte-0 write with bit 3 set produces a one-cycle pulse on arm_reset_o in the cycle after the write edge.
- R11: Bits 2 and 1 of the control word follow alarm_glitch_i and alarm_panic_i. Writes to bits 7, 2 and 1 have no effect, and writes with bus_sel_i = 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_be_i | input | 2 | Byte enables: bit 0 for bits 7..0, bit 1 for bits 15..8 |
| bus_sel_i | input | 1 | Word select: 0 = control, 1 = sample |
| bus_wdata_i | input | 16 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 16 | Registered read data |
| alarm_glitch_i | input | 1 | Power-glitch alarm from the safety logic |
| alarm_panic_i | input | 1 | Panic alarm from the safety logic |
| arm_reset_o | output | 1 | One-cycle arm-reset strobe to the safety logic |
| hold_o | output | 1 | 1 = all track-and-holds frozen |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_chan_o | output | 6 | Channel for the converter multiplexer |
| conv_done_i | input | 1 | Conversion complete pulse |
| conv_data_i | input | 12 | Conversion result, valid with conv_done_i |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Interrupt vector |

## Verification
The bench aims at the ordering of hold and start. A design that starts the converter in the same cycle as it freezes the inputs, or that issues two conversions for a write of both bytes, is caught by the cycle-exact checks on hold_o and conv_start_o. A design that sign-extends wrongly, or that updates the sample word early, shows up in the reads of full-scale values and in a read taken while a conversion is still running. Writes that release the hold, writes to read-only bits and writes to the sample address are followed by readback and by a count of conversion starts, so a design that wrongly starts a conversion or clears DONE on them is visible at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // control word bit positions
  localparam int unsigned B_HOLD    = 0;
  localparam int unsigned B_PANIC   = 1;
  localparam int unsigned B_GLITCH  = 2;
  localparam int unsigned B_ARMRST  = 3;
  localparam int unsigned B_IE      = 6;
  localparam int unsigned B_DONE    = 7;
  localparam int unsigned B_CHAN_LO = 8;
  // interrupt vector, octal 134
  localparam logic [7:0] IRQ_VEC = 8'o134;
endpackage

// File: rtl/adc_seq_csr.sv
module adc_seq_csr
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  input  logic              sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CHAN_W-1:0] chan_q,
  output logic              ie_q,
  output logic              ie_d,
  output logic              hold_q,
  output logic              arm_rst_q,
  output logic              start_req
);
  logic wr_lo, wr_hi;

  assign wr_lo = wr_i && !sel_i && be_i[0];
  assign wr_hi = wr_i && !sel_i && be_i[1];

  // a channel write or a hold-set write requests a conversion
  assign start_req = wr_hi || (wr_lo && wdata_i[B_HOLD]);
  assign ie_d      = wr_lo ? wdata_i[B_IE] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q    <= '0;
      ie_q      <= 1'b0;
      hold_q    <= 1'b0;
      arm_rst_q <= 1'b0;
    end else begin
      arm_rst_q <= wr_lo && wdata_i[B_ARMRST];
      ie_q      <= ie_d;
      if (wr_hi) chan_q <= wdata_i[B_CHAN_LO +: CHAN_W];
      if (wr_lo) hold_q <= wdata_i[B_HOLD];
    end
  end
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              ie_d,
  input  logic              conv_done_i,
  input  logic [ADC_W-1:0]  conv_data_i,
  output logic              conv_start_o,
  output logic              done_q,
  output logic [WORD_W-1:0] sample_q,
  output logic              irq_o
);
  localparam int unsigned EXT_W = WORD_W - ADC_W;

  logic              pend_q, start_q, busy_q, irq_q;
  logic              accept, done_d;
  logic [WORD_W-1:0] sample_d;

  // sign extension; the variant depends on whether padding is needed
  generate
    if (EXT_W > 0) begin : g_sext
      assign sample_d = {{EXT_W{conv_data_i[ADC_W-1]}}, conv_data_i};
    end else begin : g_plain
      assign sample_d = conv_data_i[WORD_W-1:0];
    end
  endgenerate

  // a completion counts only for the conversion actually issued
  assign accept = conv_done_i && busy_q && !start_req;
  assign done_d = start_req ? 1'b0 : (accept ? 1'b1 : done_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      sample_q <= '0;
    end else begin
      pend_q  <= start_req;
      start_q <= pend_q;
      done_q  <= done_d;
      irq_q   <= done_d && ie_d;
      if (start_req)        busy_q <= 1'b0;
      else if (start_q)     busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
      if (accept) sample_q <= sample_d;
    end
  end

  assign conv_start_o = start_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/adc_seq_rdmux.sv
module adc_seq_rdmux
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [CHAN_W-1:0] chan_q,
  input  logic              done_q,
  input  logic              ie_q,
  input  logic              hold_q,
  input  logic              glitch_i,
  input  logic              panic_i,
  input  logic [WORD_W-1:0] sample_q,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] ctl_word;

  always_comb begin
    ctl_word                       = '0;
    ctl_word[B_CHAN_LO +: CHAN_W]  = chan_q;
    ctl_word[B_DONE]               = done_q;
    ctl_word[B_IE]                 = ie_q;
    ctl_word[B_GLITCH]             = glitch_i;
    ctl_word[B_PANIC]              = panic_i;
    ctl_word[B_HOLD]               = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_i ? sample_q : ctl_word;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_be_i,
  input  logic              bus_sel_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              alarm_glitch_i,
  input  logic              alarm_panic_i,
  output logic              arm_reset_o,
  output logic              hold_o,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [ADC_W-1:0]  conv_data_i,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);
  logic [CHAN_W-1:0] chan_q;
  logic              ie_q, ie_d, hold_q, arm_rst_q, start_req;
  logic              done_q;
  logic [WORD_W-1:0] sample_q;

  adc_seq_csr #(.CHAN_W(CHAN_W), .WORD_W(WORD_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (bus_wr_i),
    .be_i      (bus_be_i),
    .sel_i     (bus_sel_i),
    .wdata_i   (bus_wdata_i),
    .chan_q    (chan_q),
    .ie_q      (ie_q),
    .ie_d      (ie_d),
    .hold_q    (hold_q),
    .arm_rst_q (arm_rst_q),
    .start_req (start_req)
  );

  adc_seq_conv #(.ADC_W(ADC_W), .WORD_W(WORD_W)) u_conv (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .ie_d         (ie_d),
    .conv_done_i  (conv_done_i),
    .conv_data_i  (conv_data_i),
    .conv_start_o (conv_start_o),
    .done_q       (done_q),
    .sample_q     (sample_q),
    .irq_o        (irq_o)
  );

  adc_seq_rdmux #(.CHAN_W(CHAN_W), .WORD_W(WORD_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (bus_rd_i),
    .sel_i    (bus_sel_i),
    .chan_q   (chan_q),
    .done_q   (done_q),
    .ie_q     (ie_q),
    .hold_q   (hold_q),
    .glitch_i (alarm_glitch_i),
    .panic_i  (alarm_panic_i),
    .sample_q (sample_q),
    .rdata_o  (bus_rdata_o)
  );

  assign arm_reset_o = arm_rst_q;
  assign hold_o      = hold_q;
  assign conv_chan_o = chan_q;
  assign irq_vec_o   = IRQ_VEC;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic [1:0]        bus_be_i,
  input logic              bus_sel_i,
  input logic [WORD_W-1:0] bus_wdata_i,
  input logic              hold_o,
  input logic              conv_start_o,
  input logic              arm_reset_o,
  input logic              irq_o,
  input logic              done_q,
  input logic              ie_q,
  input logic [WORD_W-1:0] sample_q
);
  logic wr_lo, wr_hi;
  assign wr_lo = bus_wr_i && !bus_sel_i && bus_be_i[0];
  assign wr_hi = bus_wr_i && !bus_sel_i && bus_be_i[1];

  p_chan_start_r3: assert property (@(posedge clk) disable iff (rst)
    wr_hi |-> ##2 conv_start_o);

  p_hold_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && bus_wdata_i[0]) |=> hold_o);

  p_hold_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !bus_wdata_i[0]) |=> !hold_o);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_hi || (wr_lo && bus_wdata_i[0])) |=> !done_q);

  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (done_q && ie_q));

  p_sample_edge_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_q) |-> $rose(done_q));

  p_armrst_src_r10: assert property (@(posedge clk) disable iff (rst)
    arm_reset_o |-> $past(wr_lo && bus_wdata_i[3]));
endmodule

bind adc_seq adc_seq_chk #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_wr_i     (bus_wr_i),
  .bus_be_i     (bus_be_i),
  .bus_sel_i    (bus_sel_i),
  .bus_wdata_i  (bus_wdata_i),
  .hold_o       (hold_o),
  .conv_start_o (conv_start_o),
  .arm_reset_o  (arm_reset_o),
  .irq_o        (irq_o),
  .done_q       (done_q),
  .ie_q         (ie_q),
  .sample_q     (sample_q)
);

// File: tb/adc_seq_tb_top.sv
`timescale 1ns/1ps
module adc_seq_tb_top;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        glitch = 1'b0, panic = 1'b0;
  logic        arm_reset, hold, conv_start, conv_done = 1'b0, irq;
  logic [5:0]  conv_chan;
  logic [11:0] conv_data = '0;
  logic [7:0]  irq_vec;

  int          n_chk = 0, n_fail = 0;
  int          lat_cnt = 0, n_starts = 0;
  logic [11:0] conv_value = '0;
  logic [5:0]  seen_chan = '0;
  logic        seen_hold = 1'b0;
  bit          finished = 0;

  always #2 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_be_i(bus_be),
    .bus_sel_i(bus_sel), .bus_wdata_i(bus_wdata), .bus_rd_i(bus_rd),
    .bus_rdata_o(bus_rdata), .alarm_glitch_i(glitch), .alarm_panic_i(panic),
    .arm_reset_o(arm_reset), .hold_o(hold), .conv_start_o(conv_start),
    .conv_chan_o(conv_chan), .conv_done_i(conv_done), .conv_data_i(conv_data),
    .irq_o(irq), .irq_vec_o(irq_vec)
  );

  // converter model: fixed latency after each start pulse
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = conv_value;
      end
    end
    if (conv_start) begin
      lat_cnt   = LAT;
      seen_chan = conv_chan;
      seen_hold = hold;
      n_starts  = n_starts + 1;
    end
  end

  function automatic logic [15:0] exp_ctl(int ch, bit dn, bit ie, bit gl, bit pn, bit hd);
    logic [15:0] w;
    w = 16'(ch) << 8;
    w[7] = dn; w[6] = ie; w[2] = gl; w[1] = pn; w[0] = hd;
    return w;
  endfunction

  function automatic logic [15:0] sext(logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic s = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_be = be; bus_wdata = d; bus_sel = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00; bus_sel = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [15:0] q);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = s;
    @(negedge clk);
    bus_rd = 1'b0; bus_sel = 1'b0;
    q = bus_rdata;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] q;
    int          s0;
    void'($urandom(32'd20240611));
    wait_cycles(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, q); check("R1 ctl after reset", q, 16'h0000);
    rd(1'b1, q); check("R1 sample after reset", q, 16'h0000);
    check("R1 outputs low", {12'h0, irq, hold, conv_start, arm_reset}, 16'h0);
    check("R7 vector", {8'h0, irq_vec}, 16'h005C);

    // R2 / R11 layout, read-only bits, sample address ignores writes
    wr(2'b01, 16'h00C6);
    rd(1'b0, q); check("R11 ro bits not written", q, exp_ctl(0, 0, 1, 0, 0, 0));
    glitch = 1'b1;
    rd(1'b0, q); check("R2 glitch bit2", q, exp_ctl(0, 0, 1, 1, 0, 0));
    glitch = 1'b0; panic = 1'b1;
    rd(1'b0, q); check("R2 panic bit1", q, exp_ctl(0, 0, 1, 0, 1, 0));
    panic = 1'b0;
    s0 = n_starts;
    wr(2'b11, 16'hFFFF, 1'b1);
    wait_cycles(3);
    rd(1'b0, q); check("R11 sel=1 write ignored", q, exp_ctl(0, 0, 1, 0, 0, 0));
    check("R11 no start from sel=1", 16'(n_starts - s0), 16'd0);

    // R3 channel write starts conversion, no hold
    conv_value = 12'h7FF;
    wr(2'b10, 16'h2A00);
    check("R3 hold unchanged", {15'h0, hold}, 16'h0);
    check("R3 no start yet", {15'h0, conv_start}, 16'h0);
    @(negedge clk);
    check("R3 start pulse", {15'h0, conv_start}, 16'h1);
    check("R3 channel", {10'h0, conv_chan}, 16'd42);
    @(negedge clk);
    check("R3 single pulse", {15'h0, conv_start}, 16'h0);
    wait_cycles(LAT + 2);
    rd(1'b0, q); check("R6 done set", q, exp_ctl(42, 1, 1, 0, 0, 0));
    check("R7 irq with done and ie", {15'h0, irq}, 16'h1);
    rd(1'b1, q); check("R8 max positive", q, 16'h07FF);

    // R4 hold set, then start one cycle later; R9 sample held mid-conversion
    conv_value = 12'h800;
    wr(2'b01, 16'h0041);
    check("R4 hold high after write", {15'h0, hold}, 16'h1);
    check("R4 start not yet", {15'h0, conv_start}, 16'h0);
    check("R6 irq drops with done clear", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R4 start after hold", {15'h0, conv_start}, 16'h1);
    rd(1'b1, q); check("R9 sample held during conversion", q, 16'h07FF);
    wait_cycles(LAT + 2);
    rd(1'b0, q); check("R6 done after hold conversion", q, exp_ctl(42, 1, 1, 0, 0, 1));
    rd(1'b1, q); check("R8 most negative", q, 16'hF800);
    check("R4 hold seen at start", {15'h0, seen_hold}, 16'h1);

    // R5 releasing hold starts nothing, keeps done
    s0 = n_starts;
    wr(2'b01, 16'h0040);
    check("R5 hold released", {15'h0, hold}, 16'h0);
    wait_cycles(LAT + 3);
    check("R5 no start", 16'(n_starts - s0), 16'd0);
    rd(1'b0, q); check("R5 done kept", q, exp_ctl(42, 1, 1, 0, 0, 0));

    // R10 arm reset strobe
    wr(2'b01, 16'h0048);
    check("R10 pulse high", {15'h0, arm_reset}, 16'h1);
    @(negedge clk);
    check("R10 pulse one cycle", {15'h0, arm_reset}, 16'h0);
    rd(1'b0, q); check("R10 bit3 reads zero", q, exp_ctl(42, 1, 1, 0, 0, 0));

    // R4 both bytes with hold: one conversion on the new channel
    conv_value = 12'h123;
    s0 = n_starts;
    wr(2'b11, 16'h1541);
    wait_cycles(LAT + 4);
    check("R4 one start", 16'(n_starts - s0), 16'd1);
    check("R4 new channel", {10'h0, seen_chan}, 16'h15);

    // R7 interrupt disabled
    wr(2'b11, 16'h0300);
    wait_cycles(LAT + 4);
    check("R7 irq off when ie clear", {15'h0, irq}, 16'h0);
    rd(1'b0, q); check("R6 done with ie clear", q, exp_ctl(3, 1, 0, 0, 0, 0));

    // random mix
    for (int it = 0; it < 40; it++) begin
      int ch; bit ie, hd;
      ch = int'($urandom % 64);
      ie = 1'($urandom);
      hd = 1'($urandom);
      conv_value = 12'($urandom);
      wr(2'b11, exp_ctl(ch, 0, ie, 0, 0, hd));
      wait_cycles(LAT + 4);
      rd(1'b0, q); check("R2 random ctl", q, exp_ctl(ch, 1, ie, 0, 0, hd));
      rd(1'b1, q); check("R8 random sample", q, sext(conv_value));
      check("R7 random irq", {15'h0, irq}, {15'h0, ie});
      check("R3 random channel", {10'h0, seen_chan}, 16'(ch));
    end

    summary();
  end
endmodule